// File: doc/BRIEF.md
# Bus Ownership Handshake Sequencer

This block decides when a DMA-capable bus master on a shared ISA-style system bus may drive the bus. It runs from a 20 MHz clock, where one clock is 50 ns. When the local cycle engine asks for the bus, the block raises a DMA request toward the host. It then waits for the host's acknowledge, which it passes through a two-flop synchroniser. Once the acknowledge has been seen, the block asserts its master line. It keeps every output driver off for a fixed settling time of three clocks (150 ns, against a bus minimum of 125 ns). Only after that does it enable the command, address and data drivers and grant the cycle engine the right to run memory cycles.

When the engine reports that it is done, the block gives the bus back in three steps, one clock apart. First it forces the command lines to their inactive level. Next it tri-states the command, address and data drivers and drops the DMA request. Finally it releases the master line. It does not accept a new request until the master line is off and the synchronised acknowledge has gone away. The host side provides no transfer-size or ready feedback, so the block always reports 16-bit wide memory to the cycle engine.

The reset input is asynchronous and active low, and its release is assumed to be already synchronised to the clock.

Top module: `bus_own_seq`

## Requirements
- R1: While reset is held and right after it, every output enable is 0, the DMA request, master and grant are 0, and the command-quiet output is 0.
- R2: In the idle state, an engine request seen at a clock edge makes the DMA request output 1 after that edge. An acknowledge that arrives while there is no pending request does not raise master or the DMA request.
- R3: Master rises on the third rising edge, counting as edge one the first edge at which the acknowledge input is 1 while a request is pending.
- R4: Master is 1 for exactly three clocks with all output enables and grant at 0. The command, address and data enables and the grant then all rise together.
- R5: Once grant is 1, the engine-done input sampled at a clock edge ends ownership. After that edge grant is 0, command-quiet is 1, and the enables, DMA request and master are still 1.
- R6: One clock after command-quiet rises, the command, address and data enables, the DMA request and command-quiet all go to 0 on the same edge, while master stays 1.
- R7: One clock after the enables turn off, master goes to 0.
- R8: After master falls, no new DMA request is raised until the synchronised acknowledge has been 0. An engine request that is held high meanwhile raises the DMA request on the third edge after the first edge that samples the acknowledge at 0.
- R9: The 16-bit width indication output is 1 at all times.
- R10: Engine-done is ignored while the block is requesting or settling: the grant still arrives on schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 20 MHz clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| eng_req_i | input | 1 | Cycle engine wants the bus |
| eng_done_i | input | 1 | Cycle engine has finished its bus cycles |
| eng_grant_o | output | 1 | Engine may run bus cycles |
| mem16_o | output | 1 | Target memory treated as 16 bits wide (always 1) |
| dma_req_o | output | 1 | DMA request toward the host |
| dma_ack_i | input | 1 | DMA acknowledge from the host, asynchronous |
| master_o | output | 1 | Bus master line, active high |
| cmd_oe_o | output | 1 | Command line driver enable |
| cmd_quiet_o | output | 1 | Forces command lines to their inactive level |
| addr_oe_o | output | 1 | Address line driver enable |
| data_oe_o | output | 1 | Data line driver enable |

## Verification
Two events can land in the same clock: the engine-done input can arrive in the very first cycle that grant is visible, and a new engine request can be held high all through the release while the acknowledge is still active. The bench sweeps the acknowledge delay, the ownership length (including a done that coincides with the first grant cycle), and the acknowledge hold time after release, with and without a request held across the release. At every cycle it compares every output against a cycle count derived from the requirements. It also confirms that neither the early done nor the held request shortens the settling time or the release steps.

// File: rtl/bos_pkg.sv
package bos_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_REQ      = 3'd1,
    ST_SETTLE   = 3'd2,
    ST_OWN      = 3'd3,
    ST_REL_CMD  = 3'd4,
    ST_REL_TRI  = 3'd5,
    ST_WAIT_ACK = 3'd6
  } bos_state_e;

  typedef struct packed {
    logic dma_req;
    logic master;
    logic cmd_oe;
    logic addr_oe;
    logic data_oe;
    logic cmd_quiet;
    logic grant;
  } bos_drv_t;

endpackage

// File: rtl/bos_sync.sv
module bos_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign chain_d[g] = d_i;
      end else begin : g_rest
        assign chain_d[g] = chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/bos_settle_cnt.sv
module bos_settle_cnt #(
  parameter int CLKS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic last_o
);

  localparam int CNT_W = (CLKS > 1) ? $clog2(CLKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i)              cnt_d = '0;
    else if (cnt_q != LAST) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign last_o = en_i && (cnt_q == LAST);

  a_r4_cnt_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

endmodule

// File: rtl/bos_fsm.sv
module bos_fsm
  import bos_pkg::*;
#(
  parameter int SETTLE_CLKS = 3
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     eng_req_i,
  input  logic     eng_done_i,
  input  logic     ack_s_i,
  output bos_drv_t drv_o
);

  bos_state_e state_q;
  bos_state_e state_d;
  logic       settle_en;
  logic       settle_last;

  bos_settle_cnt #(
    .CLKS (SETTLE_CLKS)
  ) i_settle_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (settle_en),
    .last_o (settle_last)
  );

  assign settle_en = (state_q == ST_SETTLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (eng_req_i)   state_d = ST_REQ;
      ST_REQ:      if (ack_s_i)     state_d = ST_SETTLE;
      ST_SETTLE:   if (settle_last) state_d = ST_OWN;
      ST_OWN:      if (eng_done_i)  state_d = ST_REL_CMD;
      ST_REL_CMD:                   state_d = ST_REL_TRI;
      ST_REL_TRI:                   state_d = ST_WAIT_ACK;
      ST_WAIT_ACK: if (!ack_s_i)    state_d = ST_IDLE;
      default:                      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    drv_o = '0;
    unique case (state_q)
      ST_REQ: begin
        drv_o.dma_req = 1'b1;
      end
      ST_SETTLE: begin
        drv_o.dma_req = 1'b1;
        drv_o.master  = 1'b1;
      end
      ST_OWN: begin
        drv_o.dma_req = 1'b1;
        drv_o.master  = 1'b1;
        drv_o.cmd_oe  = 1'b1;
        drv_o.addr_oe = 1'b1;
        drv_o.data_oe = 1'b1;
        drv_o.grant   = 1'b1;
      end
      ST_REL_CMD: begin
        drv_o.dma_req   = 1'b1;
        drv_o.master    = 1'b1;
        drv_o.cmd_oe    = 1'b1;
        drv_o.addr_oe   = 1'b1;
        drv_o.data_oe   = 1'b1;
        drv_o.cmd_quiet = 1'b1;
      end
      ST_REL_TRI: begin
        drv_o.master = 1'b1;
      end
      default: drv_o = '0;
    endcase
  end

  // R3: master only follows a synchronised acknowledge
  a_r3_master_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drv_o.master) |-> $past(ack_s_i));

  // R2: the DMA request only starts from an engine request
  a_r2_req_from_engine: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drv_o.dma_req) |-> $past(eng_req_i));

  // R5: quiet phase only follows engine done
  a_r5_quiet_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drv_o.cmd_quiet) |-> $past(eng_done_i) && $past(drv_o.grant));

  // R8: no new request while acknowledge still held
  a_r8_no_req_on_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_ACK && ack_s_i) |=> !drv_o.dma_req);

endmodule

// File: rtl/bus_own_seq.sv
module bus_own_seq
  import bos_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SETTLE_CLKS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic eng_req_i,
  input  logic eng_done_i,
  output logic eng_grant_o,
  output logic mem16_o,
  output logic dma_req_o,
  input  logic dma_ack_i,
  output logic master_o,
  output logic cmd_oe_o,
  output logic cmd_quiet_o,
  output logic addr_oe_o,
  output logic data_oe_o
);

  localparam int AGE_W = $clog2(SETTLE_CLKS + 1) + 1;
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(SETTLE_CLKS);

  logic     ack_s;
  bos_drv_t drv;

  bos_sync #(
    .STAGES (SYNC_STAGES)
  ) i_ack_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (dma_ack_i),
    .q_o    (ack_s)
  );

  bos_fsm #(
    .SETTLE_CLKS (SETTLE_CLKS)
  ) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .eng_req_i  (eng_req_i),
    .eng_done_i (eng_done_i),
    .ack_s_i    (ack_s),
    .drv_o      (drv)
  );

  assign dma_req_o   = drv.dma_req;
  assign master_o    = drv.master;
  assign cmd_oe_o    = drv.cmd_oe;
  assign addr_oe_o   = drv.addr_oe;
  assign data_oe_o   = drv.data_oe;
  assign cmd_quiet_o = drv.cmd_quiet;
  assign eng_grant_o = drv.grant;
  assign mem16_o     = 1'b1;

  // Checker state: clocks for which master has been held
  logic [AGE_W-1:0] master_age_q;
  logic [AGE_W-1:0] master_age_d;

  always_comb begin
    master_age_d = master_age_q;
    if (!master_o)                master_age_d = '0;
    else if (master_age_q != AGE_MAX) master_age_d = master_age_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) master_age_q <= '0;
    else         master_age_q <= master_age_d;
  end

  a_r4_settle_before_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(addr_oe_o) |-> master_age_q == AGE_MAX);

  a_r4_grant_needs_drivers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_grant_o |-> cmd_oe_o && addr_oe_o && data_oe_o && master_o);

  a_r6_tri_with_req_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(addr_oe_o) |-> $fell(dma_req_o) && !cmd_oe_o && !data_oe_o && master_o
                          && $past(cmd_quiet_o));

  a_r7_master_after_tri: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(master_o) |-> $past(master_o) && !$past(addr_oe_o) && !$past(dma_req_o));

endmodule

// File: tb/test_bus_own_seq.sv
module test_bus_own_seq;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic eng_req = 1'b0;
  logic eng_done = 1'b0;
  logic dma_ack = 1'b0;
  logic eng_grant, mem16, dma_req, master, cmd_oe, cmd_quiet, addr_oe, data_oe;

  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;

  bus_own_seq i_bus_own_seq (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .eng_req_i   (eng_req),
    .eng_done_i  (eng_done),
    .eng_grant_o (eng_grant),
    .mem16_o     (mem16),
    .dma_req_o   (dma_req),
    .dma_ack_i   (dma_ack),
    .master_o    (master),
    .cmd_oe_o    (cmd_oe),
    .cmd_quiet_o (cmd_quiet),
    .addr_oe_o   (addr_oe),
    .data_oe_o   (data_oe)
  );

  task automatic chk(string tag, string what, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // expected: req, master, drivers (cmd/addr/data), quiet, grant
  task automatic chk_all(string tag, logic e_req, logic e_mst, logic e_oe,
                         logic e_quiet, logic e_grant);
    chk(tag, "dma_req", dma_req, e_req);
    chk(tag, "master", master, e_mst);
    chk(tag, "cmd_oe", cmd_oe, e_oe);
    chk(tag, "addr_oe", addr_oe, e_oe);
    chk(tag, "data_oe", data_oe, e_oe);
    chk(tag, "cmd_quiet", cmd_quiet, e_quiet);
    chk(tag, "grant", eng_grant, e_grant);
    chk("R9", "mem16", mem16, 1'b1);
  endtask

  task automatic run_case(int ack_dly, int own_len, int rel_dly, bit hold, bit from_idle);
    if (from_idle && ack_dly == 3) begin
      // R10/R2: acknowledge with no request pending is ignored
      dma_ack = 1'b1;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk_all("R2", 0, 0, 0, 0, 0);
      end
      dma_ack = 1'b0;
      for (int k = 0; k < 3; k++) @(negedge clk);
    end
    eng_req  = 1'b1;
    eng_done = ack_dly[0];          // R10: done outside ownership
    @(negedge clk);
    chk_all("R2", 1, 0, 0, 0, 0);
    for (int k = 0; k < ack_dly; k++) begin
      @(negedge clk);
      chk_all("R3", 1, 0, 0, 0, 0);
    end
    dma_ack = 1'b1;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk_all("R3", 1, 0, 0, 0, 0);
    end
    @(negedge clk);
    chk_all("R3", 1, 1, 0, 0, 0);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk_all("R4", 1, 1, 0, 0, 0);
    end
    @(negedge clk);
    chk_all("R10", 1, 1, 1, 0, 1);
    if (!hold) eng_req = 1'b0;
    for (int k = 0; k < own_len; k++) begin
      eng_done = 1'b0;
      @(negedge clk);
      chk_all("R5", 1, 1, 1, 0, 1);
    end
    eng_done = 1'b1;
    @(negedge clk);
    chk_all("R5", 1, 1, 1, 1, 0);
    eng_done = 1'b0;
    @(negedge clk);
    chk_all("R6", 0, 1, 0, 0, 0);
    @(negedge clk);
    chk_all("R7", 0, 0, 0, 0, 0);
    for (int k = 0; k < rel_dly; k++) begin
      @(negedge clk);
      chk_all("R8", 0, 0, 0, 0, 0);
    end
    dma_ack = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk_all("R8", 0, 0, 0, 0, 0);
    end
    if (hold) begin
      @(negedge clk);
      chk_all("R8", 1, 0, 0, 0, 0);
    end
  endtask

  initial begin
    fork
      begin
        #5;
        chk_all("R1", 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        chk_all("R1", 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1", 0, 0, 0, 0, 0);
        begin
          bit idle_start = 1'b1;
          for (int h = 0; h < 2; h++)
            for (int a = 0; a < 4; a++)
              for (int o = 0; o < 4; o++)
                for (int r = 0; r < 3; r++) begin
                  run_case(a, o, r, h[0], idle_start);
                  idle_start = !h[0];
                end
        end
      end
      begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule